// File: doc/BRIEF.md
# Multi-Mode Shift Register Counter

This block is a small register of D flip-flops on one clock whose behaviour each cycle is picked by a three-bit mode code. It can act as a storage register that holds or loads a parallel word. It can act as a serial shifter in either direction, with one serial input per direction and a serial output. It can also run as a self-sequencing counter, either as a ring counter or as a twisted-ring (Johnson) counter. The parallel output always shows the stored word.

A recirculate control turns serial readout into a non-destructive read. The bit leaving the register is fed back into the vacated stage, so after one full pass of shifts the register holds its original word again. Without it, a pass with a zero serial input leaves the register empty.

A synchronous clear takes priority over the mode. In ring mode it plants a single one in the first stage, and in every other mode it empties the register. Both counter modes recover by themselves from patterns outside their sequence. Ring mode reloads the one-hot seed, and Johnson mode falls back to all zeros.

Top module: `mode_shift_reg`

## Requirements
- R1: A low `rst_n` sampled at a rising clock edge sets `par_out` to all zeros at that edge.
- R2: Mode codes are 000 hold, 001 shift right, 010 shift left, 011 load, 100 ring, 101 Johnson. Codes 110 and 111 act as hold, and in hold `par_out` stays unchanged.
- R3: In load mode (011) the register takes `par_in` at the next edge.
- R4: In shift-right mode (001) each edge moves bit i to bit i-1, and the serial right input enters bit WIDTH-1 (the first stage). With a zero serial input this halves the value, rounding down.
- R5: In shift-left mode (010) each edge moves bit i to bit i+1, and the serial left input enters bit 0. With a zero serial input this doubles the value, modulo 2^WIDTH.
- R6: With `recirc` high, a shift re-enters the outgoing bit in place of the serial input: bit 0 goes to bit WIDTH-1 for right shifts, and bit WIDTH-1 goes to bit 0 for left shifts. WIDTH such shifts restore the original word.
- R7: With `recirc` low and a zero serial input, WIDTH shifts leave the register all zeros.
- R8: `ser_out` equals bit WIDTH-1 in shift-left mode and bit 0 in every other mode.
- R9: In ring mode (100), a one-hot word rotates right with bit 0 moving to bit WIDTH-1, and it returns to its start after WIDTH edges.
- R10: A high `clear` in ring mode loads a one in bit WIDTH-1 and zeros elsewhere.
- R11: A high `clear` in any mode other than ring loads all zeros, overriding the mode.
- R12: In ring mode, a word that is not one-hot is replaced by the one-hot seed (bit WIDTH-1 set) at the next edge.
- R13: In Johnson mode (101), the inverse of bit 0 enters bit WIDTH-1 while the rest shift right. Starting from zero this visits 2*WIDTH words (1000, 1100, 1110, 1111, 0111, 0011, 0001, 0000 for width 4).
- R14: In Johnson mode, a word that is not one of those 2*WIDTH words is replaced by all zeros at the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| mode | input | 3 | Operating mode code |
| clear | input | 1 | Synchronous clear, seeds ring mode |
| recirc | input | 1 | Feed outgoing serial bit back in |
| ser_in_r | input | 1 | Serial input for right shifts |
| ser_in_l | input | 1 | Serial input for left shifts |
| par_in | input | WIDTH | Parallel load data |
| par_out | output | WIDTH | Current register contents |
| ser_out | output | 1 | Serial output bit |

## Verification
The bench sweeps every stored word against every mode code, both serial input levels and both recirculate settings, and predicts each next word arithmetically. This exposes a shifter that moves bits the wrong way, takes the wrong serial input, or lets an unused code disturb the register. Words loaded just before ring and Johnson cycles include every invalid pattern, so a counter that keeps circulating a bad pattern instead of reseeding is caught. Clear is applied in every mode, which catches a ring seed leaking into other modes or a mode winning over clear. Full-pass shifts with and without recirculation show whether readout destroys or preserves the data. The two counter periods are walked edge by edge, which catches a missing inversion or a wrong seed.

// File: rtl/msr_pkg.sv
// Package: shared constants for the multi-mode shift register.
// Assumes a three-bit mode code; unlisted codes are treated as hold.
package msr_pkg;
    localparam int MODE_W = 3;

    localparam logic [MODE_W-1:0] MODE_HOLD = 3'd0;
    localparam logic [MODE_W-1:0] MODE_SHR  = 3'd1;
    localparam logic [MODE_W-1:0] MODE_SHL  = 3'd2;
    localparam logic [MODE_W-1:0] MODE_LOAD = 3'd3;
    localparam logic [MODE_W-1:0] MODE_RING = 3'd4;
    localparam logic [MODE_W-1:0] MODE_JOHN = 3'd5;
endpackage

// File: rtl/msr_stage.sv
// Module: one storage stage of the register, a D flip-flop with a
// synchronous active-low reset to zero. Assumes a single clock domain.
module msr_stage (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    // Capture the next value, or zero while reset is low.
    always_ff @(posedge clk) begin
        if (!rst_n) q <= 1'b0;
        else        q <= d;
    end
endmodule

// File: rtl/msr_pattern_check.sv
// Module: classifies the stored word for the two counter modes.
// ring_ok is high for a one-hot word. john_ok is high when the word has
// at most one boundary between adjacent bits, which is exactly the set
// of 2*WIDTH words a Johnson counter passes through.
// Assumes WIDTH >= 2.
module msr_pattern_check #(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] q,
    output logic             ring_ok,
    output logic             john_ok
);
    localparam int EDGES = WIDTH - 1;

    logic [EDGES-1:0] boundary;

    // One boundary flag per adjacent pair of stages.
    for (genvar i = 0; i < EDGES; i++) begin : g_edge
        assign boundary[i] = q[i] ^ q[i+1];
    end

    // Count set bits and boundaries to decide sequence membership.
    always_comb begin
        ring_ok = $onehot(q);
        john_ok = ($countones(boundary) <= 1);
    end
endmodule

// File: rtl/msr_next_state.sv
// Module: next-state and serial-output logic for the register.
// Clear wins over the mode. Right shifts move toward bit 0 and insert at
// bit WIDTH-1; left shifts move toward bit WIDTH-1 and insert at bit 0.
// Counter modes reseed when the current word is outside their sequence.
// Assumes WIDTH >= 2.
module msr_next_state
    import msr_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0]  q,
    input  logic [MODE_W-1:0] mode,
    input  logic              clear,
    input  logic              recirc,
    input  logic              ser_in_r,
    input  logic              ser_in_l,
    input  logic [WIDTH-1:0]  par_in,
    input  logic              ring_ok,
    input  logic              john_ok,
    output logic [WIDTH-1:0]  d,
    output logic              ser_out
);
    localparam int               MSB       = WIDTH - 1;
    localparam logic [WIDTH-1:0] RING_SEED = {1'b1, {(WIDTH-1){1'b0}}};

    logic fill_r;
    logic fill_l;

    // Choose the bit entering each end: external input or the bit leaving.
    always_comb begin
        fill_r = recirc ? q[0]   : ser_in_r;
        fill_l = recirc ? q[MSB] : ser_in_l;
    end

    // Serial output taps the stage that is leaving in the current direction.
    always_comb begin
        ser_out = (mode == MODE_SHL) ? q[MSB] : q[0];
    end

    // Select the next word from clear, then the mode.
    always_comb begin
        d = q;
        if (clear) begin
            d = (mode == MODE_RING) ? RING_SEED : '0;
        end else begin
            case (mode)
                MODE_SHR:  d = {fill_r, q[MSB:1]};
                MODE_SHL:  d = {q[MSB-1:0], fill_l};
                MODE_LOAD: d = par_in;
                MODE_RING: d = ring_ok ? {q[0], q[MSB:1]} : RING_SEED;
                MODE_JOHN: d = john_ok ? {~q[0], q[MSB:1]} : '0;
                default:   d = q;
            endcase
        end
    end
endmodule

// File: rtl/mode_shift_reg.sv
// Module: multi-mode shift register counter (top).
// A chain of WIDTH D flip-flops on one clock, steered by a mode code:
// hold, right/left serial shift, parallel load, ring and Johnson count.
// Assumes synchronous active-low reset and WIDTH >= 2.
module mode_shift_reg
    import msr_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [MODE_W-1:0]    mode,
    input  logic                 clear,
    input  logic                 recirc,
    input  logic                 ser_in_r,
    input  logic                 ser_in_l,
    input  logic [WIDTH-1:0]     par_in,
    output logic [WIDTH-1:0]     par_out,
    output logic                 ser_out
);
    logic [WIDTH-1:0] stage_q;
    logic [WIDTH-1:0] stage_d;
    logic             ring_ok;
    logic             john_ok;

    msr_pattern_check #(.WIDTH(WIDTH)) u_pattern (
        .q       (stage_q),
        .ring_ok (ring_ok),
        .john_ok (john_ok)
    );

    msr_next_state #(.WIDTH(WIDTH)) u_next (
        .q        (stage_q),
        .mode     (mode),
        .clear    (clear),
        .recirc   (recirc),
        .ser_in_r (ser_in_r),
        .ser_in_l (ser_in_l),
        .par_in   (par_in),
        .ring_ok  (ring_ok),
        .john_ok  (john_ok),
        .d        (stage_d),
        .ser_out  (ser_out)
    );

    // One flip-flop per bit position.
    for (genvar i = 0; i < WIDTH; i++) begin : g_stage
        msr_stage u_stage (
            .clk   (clk),
            .rst_n (rst_n),
            .d     (stage_d[i]),
            .q     (stage_q[i])
        );
    end

    assign par_out = stage_q;
endmodule

// File: rtl/mode_shift_reg_checker.sv
// Module: property checker for mode_shift_reg, attached by bind.
// Observes ports only. Assumes WIDTH >= 2.
module mode_shift_reg_checker
    import msr_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [MODE_W-1:0]    mode,
    input logic                 clear,
    input logic                 recirc,
    input logic                 ser_in_r,
    input logic                 ser_in_l,
    input logic [WIDTH-1:0]     par_in,
    input logic [WIDTH-1:0]     par_out,
    input logic                 ser_out
);
    localparam int               MSB  = WIDTH - 1;
    localparam logic [WIDTH-1:0] SEED = {1'b1, {(WIDTH-1){1'b0}}};

    p_reset_r1: assert property (@(posedge clk)
        !rst_n |=> par_out == '0);

    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && (mode == MODE_HOLD || mode == 3'd6 || mode == 3'd7))
        |=> $stable(par_out));

    p_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && mode == MODE_LOAD) |=> par_out == $past(par_in));

    p_shr_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && mode == MODE_SHR && !recirc)
        |=> par_out == {$past(ser_in_r), $past(par_out[MSB:1])});

    p_shl_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && mode == MODE_SHL && !recirc)
        |=> par_out == {$past(par_out[MSB-1:0]), $past(ser_in_l)});

    p_recirc_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && mode == MODE_SHR && recirc)
        |=> par_out == {$past(par_out[0]), $past(par_out[MSB:1])});

    p_serout_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_SHL) |-> ser_out == par_out[MSB]);

    p_ring_rot_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && mode == MODE_RING && $onehot(par_out))
        |=> par_out == {$past(par_out[0]), $past(par_out[MSB:1])});

    p_clr_ring_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (clear && mode == MODE_RING) |=> par_out == SEED);

    p_clr_other_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (clear && mode != MODE_RING) |=> par_out == '0);

    p_ring_fix_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && mode == MODE_RING && !$onehot(par_out))
        |=> par_out == SEED);

    p_john_start_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && mode == MODE_JOHN && par_out == '0)
        |=> par_out == SEED);
endmodule

bind mode_shift_reg mode_shift_reg_checker #(.WIDTH(WIDTH)) u_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode     (mode),
    .clear    (clear),
    .recirc   (recirc),
    .ser_in_r (ser_in_r),
    .ser_in_l (ser_in_l),
    .par_in   (par_in),
    .par_out  (par_out),
    .ser_out  (ser_out)
);

// File: tb/mode_shift_reg_bench.sv
`timescale 1ns/1ps
// Bench: near-exhaustive sweep of a 4-bit configuration with an
// arithmetic model of each mode.
module mode_shift_reg_bench;
    localparam int W = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [2:0]   mode = 3'd0;
    logic         clear = 1'b0;
    logic         recirc = 1'b0;
    logic         ser_in_r = 1'b0;
    logic         ser_in_l = 1'b0;
    logic [W-1:0] par_in = '0;
    logic [W-1:0] par_out;
    logic         ser_out;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    mode_shift_reg #(.WIDTH(W)) u_mode_shift_reg (
        .clk(clk), .rst_n(rst_n), .mode(mode), .clear(clear),
        .recirc(recirc), .ser_in_r(ser_in_r), .ser_in_l(ser_in_l),
        .par_in(par_in), .par_out(par_out), .ser_out(ser_out)
    );

    task automatic chk(input string tag, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, got, exp);
        end
    endtask

    // Johnson sequence membership: k ones at the top or k ones at the bottom.
    function automatic bit john_valid(input int v);
        for (int k = 0; k <= W; k++) begin
            if (v == ((1 << k) - 1)) return 1'b1;
            if (v == (((1 << W) - 1) & ~((1 << (W - k)) - 1))) return 1'b1;
        end
        return 1'b0;
    endfunction

    function automatic int model(input int v, input int m, input int sr,
                                 input int sl, input int rc, input int pin);
        int top;
        top = 1 << (W - 1);
        case (m)
            1: return (v >> 1) + (rc != 0 ? (v % 2) : sr) * top;
            2: return ((v * 2) % (1 << W)) + (rc != 0 ? v / top : sl);
            3: return pin;
            4: return ($countones(v[W-1:0]) == 1) ? ((v >> 1) + (v % 2) * top) : top;
            5: return john_valid(v) ? ((v >> 1) + (1 - v % 2) * top) : 0;
            default: return v;
        endcase
    endfunction

    function automatic string mtag(input int m);
        case (m)
            1: return "R4/R6 shift right";
            2: return "R5/R6 shift left";
            3: return "R3 load";
            4: return "R9/R12 ring";
            5: return "R13/R14 johnson";
            default: return "R2 hold";
        endcase
    endfunction

    // Apply inputs now (just after a falling edge), wait for the next falling edge.
    task automatic step(input int m, input int sr, input int sl, input int rc,
                        input int clr, input int pin);
        mode = m[2:0]; ser_in_r = sr[0]; ser_in_l = sl[0];
        recirc = rc[0]; clear = clr[0]; par_in = pin[W-1:0];
        @(negedge clk);
    endtask

    task automatic load(input int v);
        step(3, 0, 0, 0, 0, v);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog (all requirements): actual hang expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int exp;
        @(negedge clk);
        @(negedge clk);
        chk("R1 reset value", par_out, 0);
        rst_n = 1'b1;

        // Sweep: every word, mode code, serial level and recirc setting.
        for (int v = 0; v < (1 << W); v++) begin
            for (int m = 0; m < 8; m++) begin
                for (int sr = 0; sr < 2; sr++) begin
                    for (int rc = 0; rc < 2; rc++) begin
                        load(v);
                        if (m == 0 && sr == 0 && rc == 0)
                            chk("R3 load", par_out, v);
                        mode = m[2:0]; ser_in_r = sr[0]; ser_in_l = ~sr[0];
                        recirc = rc[0]; par_in = ~v[W-1:0];
                        #2;
                        chk("R8 serial out", ser_out,
                            (m == 2) ? (v >> (W - 1)) % 2 : v % 2);
                        @(negedge clk);
                        exp = model(v, m, sr, 1 - sr, rc, (~v) & ((1 << W) - 1));
                        chk(mtag(m), par_out, exp);
                    end
                end
            end
        end

        // Clear in every mode, from every word.
        for (int v = 0; v < (1 << W); v++) begin
            for (int m = 0; m < 8; m++) begin
                load(v);
                step(m, 1, 1, 0, 1, v);
                if (m == 4) chk("R10 clear ring seed", par_out, 1 << (W - 1));
                else        chk("R11 clear zeros", par_out, 0);
            end
        end

        // Ring period from the seed.
        step(4, 0, 0, 0, 1, 0);
        for (int i = 1; i <= W; i++) begin
            step(4, 1, 1, 0, 0, 0);
            chk("R9 ring rotation", par_out, (1 << (W - 1)) >> (i % W));
        end

        // Johnson period from zero.
        step(5, 0, 0, 0, 1, 0);
        for (int i = 1; i <= 2 * W; i++) begin
            step(5, 1, 1, 0, 0, 0);
            if (i <= W) exp = ((1 << W) - 1) & ~((1 << (W - i)) - 1);
            else        exp = (1 << (2 * W - i)) - 1;
            chk("R13 johnson sequence", par_out, exp);
        end

        // Ring reseed from an invalid word, then a normal rotation.
        load(6);
        step(4, 0, 0, 0, 0, 0);
        chk("R12 ring reseed", par_out, 1 << (W - 1));
        step(4, 0, 0, 0, 0, 0);
        chk("R12 ring after reseed", par_out, 1 << (W - 2));

        // Johnson recovery from an invalid word.
        load(9);
        step(5, 0, 0, 0, 0, 0);
        chk("R14 johnson recovery", par_out, 0);

        // Non-destructive readout both directions.
        load(11);
        for (int i = 0; i < W; i++) step(1, 0, 0, 1, 0, 0);
        chk("R6 recirc right restores", par_out, 11);
        for (int i = 0; i < W; i++) step(2, 0, 0, 1, 0, 0);
        chk("R6 recirc left restores", par_out, 11);

        // Destructive readout.
        load(13);
        for (int i = 0; i < W; i++) step(1, 0, 0, 0, 0, 0);
        chk("R7 right readout empties", par_out, 0);
        load(13);
        for (int i = 0; i < W; i++) step(2, 0, 0, 0, 0, 0);
        chk("R7 left readout empties", par_out, 0);

        // Arithmetic meaning of the shifts.
        load(12);
        step(1, 0, 0, 0, 0, 0);
        chk("R4 halve", par_out, 6);
        step(2, 0, 0, 0, 0, 0);
        chk("R5 double", par_out, 12);

        // Reset in the middle of operation.
        load(7);
        rst_n = 1'b0;
        step(3, 0, 0, 0, 0, 5);
        chk("R1 reset overrides load", par_out, 0);
        rst_n = 1'b1;
        step(0, 0, 0, 0, 0, 0);
        chk("R2 hold after reset", par_out, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule